// File: doc/BRIEF.md
# Serial Synthesizer Programming Slave

This block receives configuration words for two frequency synthesizers from a baseband processor over a three-wire serial link: a serial clock, a serial data line and an active-high frame enable. The three pins are brought into the system clock domain through synchronizers, and their edges are detected there. While the enable is high, each rising edge of the serial clock shifts one data bit into a 24-bit word. The first eight bits are an address and the last sixteen are data, and the most significant bit of each arrives first.

When the enable falls, the word is committed, but only if exactly 24 serial clock edges were captured in the frame. The address then selects which synthesizer register takes the word. Each synthesizer register holds an integer divide count, a swallow count and a fractional count. A write to the first synthesizer also sets the reference edge polarity. A write to the second synthesizer also sets the receive filter path. Each synthesizer has a flag that shows it has been written at least once. The outputs are registered buses that feed the divider logic directly.

Top module: `syn_prog_top`

## Requirements
- R1: While reset is asserted and after reset is released, every output is zero. This covers all counts, both mode outputs and both programmed flags.
- R2: Bit order and frame: the first bit captured in a frame is word bit 23, and word[23:16] is the address. For address 0x00 the word is written to synthesizer 1: N = word[15:9], F = {word[8], word[3:0]}, S = word[7:5], and ref_rise_o = word[4]. ref_rise_o is 1 when the rising reference edge is used and 0 when the falling edge is used.
- R3: A word with address 0x01 updates synthesizer 2 with the same field positions, and filt_a_o takes word[4]. filt_a_o is 1 for receive path A and 0 for path B. Synthesizer 1 and ref_rise_o do not change.
- R4: A word with any other address (for example 0x02 or 0x80) changes no output.
- R5: A frame that captures 23 or 25 serial clock edges is discarded, and no output changes.
- R6: A fractional value above 17 (for example 18 or 31) is stored as 17. Values from 0 to 17 are stored unchanged.
- R7: The programmed flag of a synthesizer goes to 1 on the first accepted write to that synthesizer's address. It stays at 1 through later writes, including an all-zero write.
- R8: A frame starts only on a rising edge of the enable. Pins held high from reset carry no write. Serial clock edges seen while the enable is low do not corrupt the next frame.
- R9: A serial clock rising edge that reaches the synchronized domain in the same cycle as the enable falling edge is not captured.
- R10: Register outputs change only in the cycle after a committed word for their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_en_i | input | 1 | Frame enable, active high |
| syn1_n_o | output | 7 | Synthesizer 1 integer count |
| syn1_s_o | output | 3 | Synthesizer 1 swallow count |
| syn1_f_o | output | 5 | Synthesizer 1 fractional count, 0..17 |
| syn2_n_o | output | 7 | Synthesizer 2 integer count |
| syn2_s_o | output | 3 | Synthesizer 2 swallow count |
| syn2_f_o | output | 5 | Synthesizer 2 fractional count, 0..17 |
| ref_rise_o | output | 1 | 1: rising reference edge, 0: falling |
| filt_a_o | output | 1 | 1: receive path A, 0: path B |
| syn1_prog_o | output | 1 | Synthesizer 1 has been written |
| syn2_prog_o | output | 1 | Synthesizer 2 has been written |

## Verification
The serial clock capture and the frame close can fall in the same system cycle. The bench provokes this by raising the serial clock and dropping the enable at the same instant, so both synchronized edges appear together. When that edge would be the 24th, the frame closes with 23 bits and must be discarded, so all outputs must hold. When it would be the 25th, the 24 bits already captured must commit with their expected field values.

// File: rtl/syn_prog_pkg.sv
`timescale 1ns/1ps
package syn_prog_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int N_W     = 7;
  localparam int S_W     = 3;
  localparam int F_W     = 5;
  localparam int NUM_SYN = 2;
  localparam logic [F_W-1:0] F_MAX = F_W'(17);

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [S_W-1:0] s;
    logic [F_W-1:0] f;
    logic           mode;
  } syn_cfg_t;

  // data layout: N [15:9], F ext [8], S [7:5], mode [4], F low [3:0]
  function automatic syn_cfg_t unpack_cfg(input logic [DATA_W-1:0] d);
    syn_cfg_t       c;
    logic [F_W-1:0] fr;
    c.n    = d[15:9];
    c.s    = d[7:5];
    c.mode = d[4];
    fr     = {d[8], d[3:0]};
    c.f    = (fr > F_MAX) ? F_MAX : fr;
    return c;
  endfunction
endpackage

// File: rtl/syn_prog_sync.sv
`timescale 1ns/1ps
module syn_prog_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  // idle lines rest high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/syn_prog_shifter.sv
`timescale 1ns/1ps
module syn_prog_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               sdata_i,
  output logic               commit_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic             en_q, sclk_q, armed_q, commit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic en_rise, en_fall, sclk_rise;

  assign en_rise   = en_i & ~en_q;
  assign en_fall   = ~en_i & en_q;
  assign sclk_rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b1;
      sclk_q   <= 1'b1;
      armed_q  <= 1'b0;
      commit_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
    end else begin
      en_q     <= en_i;
      sclk_q   <= sclk_i;
      commit_q <= 1'b0;
      if (en_rise) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (en_fall) begin
        // frame close wins over a coincident shift edge
        armed_q  <= 1'b0;
        commit_q <= armed_q && (cnt_q == CNT_FULL);
      end else if (armed_q && en_i && sclk_rise) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], sdata_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o = commit_q;
  assign word_o   = shreg_q;
endmodule

// File: rtl/syn_prog_regfile.sv
`timescale 1ns/1ps
module syn_prog_regfile
  import syn_prog_pkg::*;
#(
  parameter logic [NUM_SYN*ADDR_W-1:0] ADDR_MAP = {8'h01, 8'h00}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [FRAME_W-1:0]  word_i,
  output syn_cfg_t            cfg_o  [NUM_SYN],
  output logic [NUM_SYN-1:0]  prog_o
);
  logic [ADDR_W-1:0] addr;
  syn_cfg_t          cfg_new;

  assign addr    = word_i[FRAME_W-1:DATA_W];
  assign cfg_new = unpack_cfg(word_i[DATA_W-1:0]);

  for (genvar g = 0; g < NUM_SYN; g++) begin : g_syn
    logic     hit;
    syn_cfg_t cfg_q;
    logic     prog_q;

    assign hit = commit_i && (addr == ADDR_MAP[g*ADDR_W +: ADDR_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q  <= '0;
        prog_q <= 1'b0;
      end else if (hit) begin
        cfg_q  <= cfg_new;
        prog_q <= 1'b1;
      end
    end

    assign cfg_o[g]  = cfg_q;
    assign prog_o[g] = prog_q;
  end
endmodule

// File: rtl/syn_prog_top.sv
`timescale 1ns/1ps
module syn_prog_top
  import syn_prog_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SYN1_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] SYN2_ADDR  = 8'h01
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_en_i,
  output logic [N_W-1:0] syn1_n_o,
  output logic [S_W-1:0] syn1_s_o,
  output logic [F_W-1:0] syn1_f_o,
  output logic [N_W-1:0] syn2_n_o,
  output logic [S_W-1:0] syn2_s_o,
  output logic [F_W-1:0] syn2_f_o,
  output logic           ref_rise_o,
  output logic           filt_a_o,
  output logic           syn1_prog_o,
  output logic           syn2_prog_o
);
  logic [2:0]         pins_s;
  logic               commit;
  logic [FRAME_W-1:0] word;
  syn_cfg_t           cfg [NUM_SYN];
  logic [NUM_SYN-1:0] prog;

  syn_prog_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_en_i, ser_clk_i, ser_data_i}),
    .q_o    (pins_s)
  );

  syn_prog_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pins_s[2]),
    .sclk_i   (pins_s[1]),
    .sdata_i  (pins_s[0]),
    .commit_o (commit),
    .word_o   (word)
  );

  syn_prog_regfile #(.ADDR_MAP({SYN2_ADDR, SYN1_ADDR})) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .word_i   (word),
    .cfg_o    (cfg),
    .prog_o   (prog)
  );

  assign syn1_n_o    = cfg[0].n;
  assign syn1_s_o    = cfg[0].s;
  assign syn1_f_o    = cfg[0].f;
  assign ref_rise_o  = cfg[0].mode;
  assign syn2_n_o    = cfg[1].n;
  assign syn2_s_o    = cfg[1].s;
  assign syn2_f_o    = cfg[1].f;
  assign filt_a_o    = cfg[1].mode;
  assign syn1_prog_o = prog[0];
  assign syn2_prog_o = prog[1];
endmodule

// File: rtl/syn_prog_chk.sv
`timescale 1ns/1ps
module syn_prog_chk
  import syn_prog_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SYN1_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] SYN2_ADDR = 8'h01
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               commit_i,
  input logic [FRAME_W-1:0] word_i,
  input logic [N_W+S_W+F_W:0] syn1_i,
  input logic [N_W+S_W+F_W:0] syn2_i,
  input logic [F_W-1:0]     syn1_f_i,
  input logic [F_W-1:0]     syn2_f_i,
  input logic               syn1_prog_i,
  input logic               syn2_prog_i
);
  logic [ADDR_W-1:0] addr;
  assign addr = word_i[FRAME_W-1:DATA_W];

  // R6
  f_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn1_f_i <= F_MAX) && (syn2_f_i <= F_MAX));

  // R7
  prog_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(syn1_prog_i) && !$fell(syn2_prog_i));

  // R10
  syn1_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(syn1_i) |-> $past(commit_i && addr == SYN1_ADDR));

  // R10
  syn2_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(syn2_i) |-> $past(commit_i && addr == SYN2_ADDR));

  // R7
  prog_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(syn1_prog_i) |-> $past(commit_i && addr == SYN1_ADDR));
endmodule

bind syn_prog_top syn_prog_chk #(.SYN1_ADDR(SYN1_ADDR), .SYN2_ADDR(SYN2_ADDR)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .commit_i    (commit),
  .word_i      (word),
  .syn1_i      ({syn1_n_o, syn1_s_o, syn1_f_o, ref_rise_o}),
  .syn2_i      ({syn2_n_o, syn2_s_o, syn2_f_o, filt_a_o}),
  .syn1_f_i    (syn1_f_o),
  .syn2_f_i    (syn2_f_o),
  .syn1_prog_i (syn1_prog_o),
  .syn2_prog_i (syn2_prog_o)
);

// File: tb/test_syn_prog_top.sv
`timescale 1ns/1ps
module test_syn_prog_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdata = 1'b1, sen = 1'b1;
  logic [6:0] s1n, s2n;
  logic [2:0] s1s, s2s;
  logic [4:0] s1f, s2f;
  logic ref_rise, filt_a, p1, p2;
  int checks = 0, errors = 0;

  // expected state: {n, s, f, mode}
  logic [15:0] e1 = '0, e2 = '0;
  logic        ep1 = 1'b0, ep2 = 1'b0;

  always #2.5 clk = ~clk;

  syn_prog_top i_syn_prog_top (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata), .ser_en_i(sen),
    .syn1_n_o(s1n), .syn1_s_o(s1s), .syn1_f_o(s1f),
    .syn2_n_o(s2n), .syn2_s_o(s2s), .syn2_f_o(s2f),
    .ref_rise_o(ref_rise), .filt_a_o(filt_a), .syn1_prog_o(p1), .syn2_prog_o(p2)
  );

  function automatic logic [23:0] mk(input logic [7:0] a, input logic [6:0] n,
                                     input logic [2:0] s, input logic m, input logic [4:0] f);
    return {a, n, f[4], s, m, f[3:0]};
  endfunction

  function automatic logic [15:0] ex(input logic [6:0] n, input logic [2:0] s,
                                     input logic m, input logic [4:0] f);
    return {n, s, (f > 5'd17) ? 5'd17 : f, m};
  endfunction

  task automatic check(input string req);
    logic [33:0] got, exp;
    got = {s1n, s1s, s1f, ref_rise, s2n, s2s, s2f, filt_a, p1, p2};
    exp = {e1, e2, ep1, ep2};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic [23:0] w, input int nclk, input bit coin);
    sen = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdata = (i < 24) ? w[23-i] : 1'b0;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      if (coin && i == nclk - 1) sen = 1'b0;
      repeat (4) @(negedge clk);
    end
    sen = 1'b0;
    sdata = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset");
  endtask

  task automatic t_idle_high;
    // EN high since reset: clocks must not form a frame
    for (int i = 0; i < 24; i++) begin
      sclk = 1'b0; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (4) @(negedge clk);
    end
    sen = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 idle-high no write");
  endtask

  task automatic t_syn1;
    send(mk(8'h00, 7'h55, 3'd5, 1'b1, 5'd9), 24, 1'b0);
    e1 = ex(7'h55, 3'd5, 1'b1, 5'd9); ep1 = 1'b1;
    check("R2 syn1 write");
    check("R7 syn1 flag set");
    send(mk(8'h00, 7'h2A, 3'd2, 1'b0, 5'd16), 24, 1'b0);
    e1 = ex(7'h2A, 3'd2, 1'b0, 5'd16);
    check("R2 syn1 falling edge polarity, F ext bit");
  endtask

  task automatic t_syn2;
    send(mk(8'h01, 7'h7F, 3'd7, 1'b1, 5'd17), 24, 1'b0);
    e2 = ex(7'h7F, 3'd7, 1'b1, 5'd17); ep2 = 1'b1;
    check("R3 syn2 write path A, syn1 unchanged");
    send(mk(8'h01, 7'h11, 3'd1, 1'b0, 5'd3), 24, 1'b0);
    e2 = ex(7'h11, 3'd1, 1'b0, 5'd3);
    check("R3 syn2 path B");
  endtask

  task automatic t_clamp;
    send(mk(8'h00, 7'h03, 3'd4, 1'b1, 5'd31), 24, 1'b0);
    e1 = ex(7'h03, 3'd4, 1'b1, 5'd31);
    check("R6 F=31 clamp");
    send(mk(8'h01, 7'h04, 3'd6, 1'b1, 5'd18), 24, 1'b0);
    e2 = ex(7'h04, 3'd6, 1'b1, 5'd18);
    check("R6 F=18 clamp");
  endtask

  task automatic t_reserved;
    send(mk(8'h02, 7'h6E, 3'd3, 1'b0, 5'd1), 24, 1'b0);
    check("R4 addr 0x02 ignored");
    send(mk(8'h80, 7'h6E, 3'd3, 1'b0, 5'd1), 24, 1'b0);
    check("R4 addr 0x80 ignored");
  endtask

  task automatic t_count;
    send(mk(8'h00, 7'h01, 3'd1, 1'b0, 5'd2), 23, 1'b0);
    check("R5 23 clocks discarded");
    send(mk(8'h00, 7'h01, 3'd1, 1'b0, 5'd2), 25, 1'b0);
    check("R5 25 clocks discarded");
  endtask

  task automatic t_coincide;
    send(mk(8'h00, 7'h0F, 3'd2, 1'b0, 5'd5), 24, 1'b1);
    check("R9 24th edge with EN fall discarded");
    send(mk(8'h00, 7'h0F, 3'd2, 1'b0, 5'd5), 25, 1'b1);
    e1 = ex(7'h0F, 3'd2, 1'b0, 5'd5);
    check("R9 25th edge with EN fall, 24 captured");
  endtask

  task automatic t_stray_and_zero;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; sdata = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (4) @(negedge clk);
    end
    send(mk(8'h01, 7'h22, 3'd0, 1'b1, 5'd12), 24, 1'b0);
    e2 = ex(7'h22, 3'd0, 1'b1, 5'd12);
    check("R8 stray clocks with EN low");
    send(mk(8'h00, 7'h00, 3'd0, 1'b0, 5'd0), 24, 1'b0);
    e1 = '0;
    check("R7 flag kept after zero write");
  endtask

  initial begin
    t_reset();
    t_idle_high();
    t_syn1();
    t_syn2();
    t_clamp();
    t_reserved();
    t_count();
    t_coincide();
    t_stray_and_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule